// File: doc/BRIEF.md
# Shared-Line Write Broadcast Sequencer

A processor write that hits a cache line held in the shared state cannot finish locally, because other bus agents may hold copies of the line. This block takes over such writes. A read hit, or a write hit on a line that is not shared, is a fast cycle, and the block does not react to it. For a write hit on a shared line, the block runs a fixed series of one-cycle steps on a 32-byte block. It reads the block, updates the duplicate tag, and writes the block locally with dirty set. It then requests the system bus and waits for grant. It drives a multi-beat bus write and samples the bus shared response on one chosen beat. It rewrites the line state as clean, with the shared bit set to the sampled value. Finally it drops the bus request and acknowledges the processor.

Only one sequence runs at a time. While the block is busy, further processor requests are ignored; the requester sees the busy output and holds off until acknowledge. The block-aligned address captured when the request is accepted is driven on the operation address output for the whole sequence.

Top module: `shwr_seq`

## Requirements
- R1: A request with `cpu_wr`=0 or `cpu_shr`=0 is a fast cycle: `cpu_busy` stays 0, and no step strobe or `cpu_ack` follows.
- R2: An accepted shared write (`cpu_req`=`cpu_wr`=`cpu_shr`=1 while idle) drives `blk_rd` in the first cycle after acceptance, `dtag_upd` in the second, and `blk_wr` with `lst_dirty`=1 in the third. Each is high for exactly one cycle.
- R3: `bus_req` rises in the fourth cycle and stays high without `bus_wr` for as long as `bus_gnt` is low. The bus write starts only in the cycle after `bus_gnt` is seen high.
- R4: `bus_wr` is high for exactly WR_BEATS consecutive cycles, with `bus_req` high. `bus_gnt` is ignored once the write has started.
- R5: `line_upd` is high for one cycle directly after the last write beat, with `lst_dirty`=0.
- R6: `lst_shared` during `line_upd` equals the `bus_shared` value present on write beat SHR_BEAT, counting beats from 0. Values on the other beats have no effect.
- R7: `bus_req` stays high through the `line_upd` cycle and is low the cycle after. `cpu_ack` is a one-cycle pulse in the cycle after that, and the block is idle in the following cycle.
- R8: While `cpu_busy` is 1, new requests are ignored: the sequence timing and `op_addr` are unchanged, and the block returns to idle after the acknowledge.
- R9: While reset is held, every output except `op_addr` is 0.
- R10: `op_addr` equals the accepted `cpu_addr` with its low log2(BLK_BYTES) bits cleared (5 bits for 32-byte blocks), for every busy cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor cache cycle request |
| cpu_wr | input | 1 | Request is a write |
| cpu_shr | input | 1 | Hit line is marked shared |
| cpu_addr | input | ADDR_W | Request address |
| cpu_ack | output | 1 | Write acknowledge pulse |
| cpu_busy | output | 1 | Sequence in progress; requests ignored |
| blk_rd | output | 1 | Local block read step |
| dtag_upd | output | 1 | Duplicate tag update step |
| blk_wr | output | 1 | Local block write step |
| bus_req | output | 1 | System bus request |
| bus_gnt | input | 1 | System bus grant |
| bus_wr | output | 1 | Bus write command and data beats |
| bus_shared | input | 1 | Shared response from the bus |
| line_upd | output | 1 | Line state rewrite strobe |
| lst_dirty | output | 1 | Dirty value for block write or state rewrite |
| lst_shared | output | 1 | Shared value for the state rewrite |
| op_addr | output | ADDR_W | Block-aligned address of the operation |

## Verification
Every result is a decode of registered state, so each result is due a fixed number of cycles after acceptance, counted from the clock edge that samples the request. The local steps are due at cycles 1 to 3. The request runs from cycle 4 until G cycles later, where G is the number of cycles the bench withholds grant. The beats then run for WR_BEATS cycles, and line update, release and acknowledge follow on consecutive cycles. The bench computes that timeline from the cycle index and its own grant delay. It compares every output on every cycle at the falling edge, after the design has settled. The shared value it expects is the one it drove on beat SHR_BEAT.

// File: rtl/shwr_pkg.sv
`timescale 1ns/1ps
package shwr_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_BRD,
        ST_DTAG,
        ST_BWRL,
        ST_BREQ,
        ST_BXFER,
        ST_LUPD,
        ST_REL,
        ST_ACK
    } shwr_st_e;
endpackage

// File: rtl/shwr_beat.sv
`timescale 1ns/1ps
module shwr_beat #(
    parameter int WR_BEATS = 4,
    parameter int SHR_BEAT = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic bus_shared,
    output logic last,
    output logic shr
);
    localparam int CNT_W = $clog2(WR_BEATS + 1);
    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(WR_BEATS - 1);
    localparam logic [CNT_W-1:0] SMPL_C = CNT_W'(SHR_BEAT);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             shr;
    } beat_t;

    beat_t beat_d, beat_q;

    always_comb begin
        beat_d = beat_q;
        if (run) begin
            beat_d.cnt = beat_q.cnt + 1'b1;
            if (beat_q.cnt == SMPL_C) begin
                beat_d.shr = bus_shared;
            end
        end else begin
            beat_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q <= '0;
        end else begin
            beat_q <= beat_d;
        end
    end

    assign last = run && (beat_q.cnt == LAST_C);
    assign shr  = beat_q.shr;
endmodule

// File: rtl/shwr_ctrl.sv
`timescale 1ns/1ps
module shwr_ctrl
    import shwr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_wr,
    input  logic              cpu_shr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              bus_gnt,
    input  logic              beat_last,
    output shwr_st_e          st_o,
    output logic [ADDR_W-1:0] addr_o
);
    typedef struct packed {
        shwr_st_e          st;
        logic [ADDR_W-1:0] addr;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        unique case (ctrl_q.st)
            ST_IDLE: begin
                if (cpu_req && cpu_wr && cpu_shr) begin
                    ctrl_d.st   = ST_BRD;
                    ctrl_d.addr = {cpu_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
                end
            end
            ST_BRD:   ctrl_d.st = ST_DTAG;
            ST_DTAG:  ctrl_d.st = ST_BWRL;
            ST_BWRL:  ctrl_d.st = ST_BREQ;
            ST_BREQ:  if (bus_gnt) ctrl_d.st = ST_BXFER;
            ST_BXFER: if (beat_last) ctrl_d.st = ST_LUPD;
            ST_LUPD:  ctrl_d.st = ST_REL;
            ST_REL:   ctrl_d.st = ST_ACK;
            ST_ACK:   ctrl_d.st = ST_IDLE;
            default:  ctrl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '{st: ST_IDLE, addr: '0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign st_o   = ctrl_q.st;
    assign addr_o = ctrl_q.addr;
endmodule

// File: rtl/shwr_outdec.sv
`timescale 1ns/1ps
module shwr_outdec
    import shwr_pkg::*;
(
    input  shwr_st_e st,
    input  logic     shr,
    output logic     blk_rd,
    output logic     dtag_upd,
    output logic     blk_wr,
    output logic     bus_req,
    output logic     bus_wr,
    output logic     line_upd,
    output logic     lst_dirty,
    output logic     lst_shared,
    output logic     cpu_ack,
    output logic     cpu_busy
);
    always_comb begin
        blk_rd     = (st == ST_BRD);
        dtag_upd   = (st == ST_DTAG);
        blk_wr     = (st == ST_BWRL);
        bus_req    = (st == ST_BREQ) || (st == ST_BXFER) || (st == ST_LUPD);
        bus_wr     = (st == ST_BXFER);
        line_upd   = (st == ST_LUPD);
        lst_dirty  = (st == ST_BWRL);
        lst_shared = (st == ST_LUPD) && shr;
        cpu_ack    = (st == ST_ACK);
        cpu_busy   = (st != ST_IDLE);
    end
endmodule

// File: rtl/shwr_seq.sv
`timescale 1ns/1ps
module shwr_seq
    import shwr_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BLK_BYTES = 32,
    parameter int WR_BEATS  = 4,
    parameter int SHR_BEAT  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_wr,
    input  logic              cpu_shr,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_ack,
    output logic              cpu_busy,
    output logic              blk_rd,
    output logic              dtag_upd,
    output logic              blk_wr,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_wr,
    input  logic              bus_shared,
    output logic              line_upd,
    output logic              lst_dirty,
    output logic              lst_shared,
    output logic [ADDR_W-1:0] op_addr
);
    localparam int OFS_W = $clog2(BLK_BYTES);

    shwr_st_e st;
    logic     beat_last;
    logic     beat_shr;

    shwr_ctrl #(
        .ADDR_W (ADDR_W),
        .OFS_W  (OFS_W)
    ) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req   (cpu_req),
        .cpu_wr    (cpu_wr),
        .cpu_shr   (cpu_shr),
        .cpu_addr  (cpu_addr),
        .bus_gnt   (bus_gnt),
        .beat_last (beat_last),
        .st_o      (st),
        .addr_o    (op_addr)
    );

    shwr_beat #(
        .WR_BEATS (WR_BEATS),
        .SHR_BEAT (SHR_BEAT)
    ) i_beat (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (st == ST_BXFER),
        .bus_shared (bus_shared),
        .last       (beat_last),
        .shr        (beat_shr)
    );

    shwr_outdec i_dec (
        .st         (st),
        .shr        (beat_shr),
        .blk_rd     (blk_rd),
        .dtag_upd   (dtag_upd),
        .blk_wr     (blk_wr),
        .bus_req    (bus_req),
        .bus_wr     (bus_wr),
        .line_upd   (line_upd),
        .lst_dirty  (lst_dirty),
        .lst_shared (lst_shared),
        .cpu_ack    (cpu_ack),
        .cpu_busy   (cpu_busy)
    );
endmodule

// File: rtl/shwr_seq_chk.sv
`timescale 1ns/1ps
module shwr_seq_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_wr,
    input logic              cpu_shr,
    input logic              cpu_ack,
    input logic              cpu_busy,
    input logic              blk_rd,
    input logic              dtag_upd,
    input logic              blk_wr,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic              bus_wr,
    input logic              line_upd,
    input logic              lst_dirty,
    input logic [ADDR_W-1:0] op_addr
);
    AST_FAST_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_busy && cpu_req && !(cpu_wr && cpu_shr)) |=> !cpu_busy); // R1
    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({blk_rd, dtag_upd, blk_wr, line_upd, cpu_ack})); // R2
    AST_TAG_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        dtag_upd |-> $past(blk_rd)); // R2
    AST_WRL_AFTER_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        blk_wr |-> ($past(dtag_upd) && lst_dirty)); // R2
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_wr && !line_upd && !bus_gnt) |=> (bus_req && !bus_wr)); // R3
    AST_WR_AFTER_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_wr) |-> $past(bus_gnt)); // R3
    AST_WR_OWNS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> bus_req); // R4
    AST_UPD_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        line_upd |-> (!lst_dirty && $past(bus_wr))); // R5
    AST_REL_AFTER_UPD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_req) |-> $past(line_upd)); // R7
    AST_ACK_AFTER_REL: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |-> ($past(!bus_req) && $past(cpu_busy))); // R7
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_busy && $past(cpu_busy)) |-> $stable(op_addr)); // R8
endmodule

bind shwr_seq shwr_seq_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_wr    (cpu_wr),
    .cpu_shr   (cpu_shr),
    .cpu_ack   (cpu_ack),
    .cpu_busy  (cpu_busy),
    .blk_rd    (blk_rd),
    .dtag_upd  (dtag_upd),
    .blk_wr    (blk_wr),
    .bus_req   (bus_req),
    .bus_gnt   (bus_gnt),
    .bus_wr    (bus_wr),
    .line_upd  (line_upd),
    .lst_dirty (lst_dirty),
    .op_addr   (op_addr)
);

// File: tb/test_shwr_seq.sv
`timescale 1ns/1ps
module test_shwr_seq;
    localparam int ADDR_W   = 32;
    localparam int WR_BEATS = 4;
    localparam int SHR_BEAT = 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cpu_req = 1'b0, cpu_wr = 1'b0, cpu_shr = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic              bus_gnt = 1'b0, bus_shared = 1'b0;
    logic cpu_ack, cpu_busy, blk_rd, dtag_upd, blk_wr, bus_req, bus_wr;
    logic line_upd, lst_dirty, lst_shared;
    logic [ADDR_W-1:0] op_addr;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    shwr_seq #(.ADDR_W(ADDR_W), .WR_BEATS(WR_BEATS), .SHR_BEAT(SHR_BEAT)) i_shwr_seq (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_wr(cpu_wr), .cpu_shr(cpu_shr),
        .cpu_addr(cpu_addr), .cpu_ack(cpu_ack), .cpu_busy(cpu_busy), .blk_rd(blk_rd),
        .dtag_upd(dtag_upd), .blk_wr(blk_wr), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .bus_wr(bus_wr), .bus_shared(bus_shared), .line_upd(line_upd),
        .lst_dirty(lst_dirty), .lst_shared(lst_shared), .op_addr(op_addr)
    );

    always #10 clk = ~clk;

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Output vector {busy, blk_rd, dtag_upd, blk_wr, dirty, bus_req, bus_wr, line_upd, ack}
    function automatic logic [8:0] exp_vec(int n, int gd);
        int lx = 5 + gd;
        int lu = lx + WR_BEATS;
        exp_vec = {(n >= 1 && n <= lu + 2), n == 1, n == 2, n == 3, n == 3,
                   (n >= 4 && n <= lu), (n >= lx && n < lu), n == lu, n == lu + 2};
    endfunction

    function automatic string tag_of(int n, int gd);
        int lx = 5 + gd;
        int lu = lx + WR_BEATS;
        if (n <= 3)      return "R2";
        else if (n < lx) return "R3";
        else if (n < lu) return "R4";
        else if (n == lu) return "R5";
        else if (n <= lu + 2) return "R7";
        return "R8";
    endfunction

    task automatic run_txn(logic [ADDR_W-1:0] addr, int gd, logic [WR_BEATS-1:0] shr_beats, bit stall);
        int lx = 5 + gd;
        int lu = lx + WR_BEATS;
        logic [ADDR_W-1:0] exp_addr = {addr[ADDR_W-1:5], 5'b0};
        @(negedge clk);
        cpu_req = 1'b1; cpu_wr = 1'b1; cpu_shr = 1'b1; cpu_addr = addr;
        @(negedge clk);
        cpu_req = 1'b0;
        for (int n = 1; n <= lu + 3; n++) begin
            chk(tag_of(n, gd), "outputs",
                {cpu_busy, blk_rd, dtag_upd, blk_wr, lst_dirty, bus_req, bus_wr, line_upd, cpu_ack},
                exp_vec(n, gd));
            if (cpu_busy) chk("R10", "op_addr", op_addr, exp_addr);
            if (n == lu) chk("R6", "lst_shared", lst_shared, shr_beats[SHR_BEAT]);
            if (n < 4)       bus_gnt = 1'($urandom % 2);
            else if (n < 4 + gd) bus_gnt = 1'b0;
            else if (n == 4 + gd) bus_gnt = 1'b1;
            else if (n < lu) bus_gnt = 1'($urandom % 2);
            else bus_gnt = 1'b0;
            bus_shared = (n >= lx && n < lu) ? shr_beats[n - lx] : 1'($urandom % 2);
            if (stall && (n == 2 || n == lu)) begin
                cpu_req = 1'b1; cpu_addr = ~addr;
            end else begin
                cpu_req = 1'b0;
            end
            @(negedge clk);
        end
        bus_gnt = 1'b0;
    endtask

    task automatic fast_cycle(bit wr, bit shr);
        @(negedge clk);
        cpu_req = 1'b1; cpu_wr = wr; cpu_shr = shr; cpu_addr = $urandom;
        @(negedge clk);
        cpu_req = 1'b0;
        chk("R1", "busy after fast", cpu_busy, 0);
        chk("R1", "blk_rd after fast", blk_rd, 0);
        @(negedge clk);
        chk("R1", "activity after fast", {cpu_busy, dtag_upd, bus_req, cpu_ack}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk("R9", "reset outputs",
            {cpu_busy, blk_rd, dtag_upd, blk_wr, lst_dirty, bus_req, bus_wr, line_upd, lst_shared, cpu_ack}, 0);
        cpu_req = 1'b1; cpu_wr = 1'b1; cpu_shr = 1'b1;
        @(negedge clk);
        chk("R9", "busy under reset with request", cpu_busy, 0);
        cpu_req = 1'b0;
        rst_n = 1'b1;
        // Directed corners
        fast_cycle(1'b0, 1'b1);
        fast_cycle(1'b1, 1'b0);
        fast_cycle(1'b0, 1'b0);
        run_txn(32'h1234_567f, 0, 4'b0010, 1'b0);  // R6 only sample beat high
        run_txn(32'hdead_beef, 1, 4'b1101, 1'b0);  // R6 other beats high, ignored
        run_txn(32'h0000_0040, 12, 4'b0010, 1'b0); // R3 long grant wait
        run_txn(32'hcafe_0011, 2, 4'b1111, 1'b1);  // R8 requests while busy
        // Random mix
        for (int i = 0; i < 40; i++) begin
            if ($urandom % 4 == 0) begin
                fast_cycle(1'($urandom % 2), 1'b0);
            end else begin
                run_txn($urandom, int'($urandom % 5), 4'($urandom), 1'($urandom % 2));
            end
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule